// File: doc/BRIEF.md
# Wide register to narrow subregister bridge

This block presents a single 32-bit control/status register to a simple word-strided bus as a row of narrow subregisters. Each subregister is a whole bus word. Only its low `SUB_W` bits carry data, and the bits above them read as zero. The wide value is cut into chunks with the most significant chunk first, so the lowest word offset holds the top bits. With 8-bit chunks the register takes four words. With 16-bit chunks it takes two.

Software writes the chunks in address order. The first chunks land in shadow storage. The write to the last, least significant chunk updates the whole register in one cycle and pulses a write strobe toward the logic that uses the register. Reading the first chunk captures a copy of the whole register. The remaining chunks are read from that copy, so a multi-word read stays consistent even when hardware changes the register part way through. Hardware can load the register directly through a load port.

Top module: `csr_split_bridge`

## Requirements
- R1: While and just after reset, `reg_value`, `reg_wstrobe`, `bus_rdata` and `bus_rvalid` are all zero.
- R2: Word offset k (byte address 4k) returns bits [REG_W-1-k*SUB_W -: SUB_W] of the register in its low `SUB_W` bits. All higher bits of `bus_rdata` are zero. With `SUB_W`=8, the value 0x12345678 reads 0x12, 0x34, 0x56, 0x78 at offsets 0 to 3.
- R3: With `SUB_W`=16 the register spans offsets 0 and 1, which read 0x1234 and 0x5678 for the value 0x12345678. Offsets 2 and up are outside the register.
- R4: A write to any offset below the last one changes only shadow storage. `reg_value` stays unchanged and `reg_wstrobe` stays low.
- R5: A write to the last offset (NSUB-1) loads the full register from the shadow chunks plus the written chunk. `reg_value` shows the new value in the cycle after the write. `reg_wstrobe` is high in that cycle only.
- R6: Write data bits at positions `SUB_W` and above are ignored.
- R7: A read of offset 0 captures the whole register. Later reads of offsets 1 to NSUB-1 return slices of that capture, even if the register has changed since.
- R8: For offsets at or above NSUB, a read returns zero. A write there changes neither `reg_value` nor the shadow chunks, and produces no strobe.
- R9: `hw_load` copies `hw_data` into `reg_value` in the next cycle and does not raise `reg_wstrobe`. If a bus commit happens in the same cycle, the bus commit wins.
- R10: `bus_rvalid` is high for exactly the cycle after each read, with `bus_rdata` valid in that cycle. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word offset is bits [ADDR_W-1:2] |
| bus_wdata | input | BUS_W | Write data; only the low SUB_W bits are used |
| bus_rdata | output | BUS_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| hw_load | input | 1 | Hardware load of the register |
| hw_data | input | REG_W | Value for hardware load |
| reg_value | output | REG_W | Current committed register value |
| reg_wstrobe | output | 1 | One-cycle pulse on a bus commit |

## Verification
The hardest case to reach from the ports is a read that is split by a hardware update. Offset 0 must be read, the register must then be changed through `hw_load`, and only after that may the higher offsets be read. The bench builds exactly this order and expects the old slices, then re-reads offset 0 to confirm the new value is visible. The bench also drives a bus commit and a hardware load in the same cycle to check priority. It sweeps arithmetic patterns through both 8-bit and 16-bit builds, with junk in the unused data bits and in the low address bits.

// File: rtl/csr_split_pkg.sv
`timescale 1ns/1ps
package csr_split_pkg;
  typedef struct packed {
    logic rd;    // read request
    logic wr;    // write request
    logic hit;   // offset inside register
    logic first; // offset 0
    logic last;  // offset NSUB-1
  } csr_acc_t;
endpackage

// File: rtl/csr_split_decode.sv
`timescale 1ns/1ps
module csr_split_decode
  import csr_split_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NSUB   = 4,
  localparam int OFF_W = ADDR_W - 2
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output csr_acc_t          acc,
  output logic [OFF_W-1:0]  offs
);
  always_comb begin
    offs      = addr[ADDR_W-1:2];
    acc.rd    = sel & ~we;
    acc.wr    = sel & we;
    acc.hit   = {1'b0, offs} < (OFF_W+1)'(NSUB);
    acc.first = offs == '0;
    acc.last  = offs == OFF_W'(NSUB - 1);
  end
endmodule

// File: rtl/csr_split_wr.sv
`timescale 1ns/1ps
module csr_split_wr
  import csr_split_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int SUB_W = 8,
  parameter int BUS_W = 32,
  parameter int OFF_W = 4,
  localparam int NSUB = REG_W / SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  csr_acc_t         acc,
  input  logic [OFF_W-1:0] offs,
  input  logic [BUS_W-1:0] wdata,
  input  logic             hw_load,
  input  logic [REG_W-1:0] hw_data,
  output logic [REG_W-1:0] reg_q,
  output logic             wstrobe
);
  logic [SUB_W-1:0] shadow [NSUB-1];
  logic [REG_W-1:0] nxt;
  logic             commit;

  assign commit = acc.wr & acc.hit & acc.last;

  for (genvar k = 0; k < NSUB - 1; k++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)
        shadow[k] <= '0;
      else if (acc.wr && acc.hit && offs == OFF_W'(k))
        shadow[k] <= wdata[SUB_W-1:0];
    end
    assign nxt[REG_W-1-k*SUB_W -: SUB_W] = shadow[k];
  end
  assign nxt[SUB_W-1:0] = wdata[SUB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      wstrobe <= 1'b0;
    end else begin
      wstrobe <= commit;
      if (commit)
        reg_q <= nxt;
      else if (hw_load)
        reg_q <= hw_data;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!commit && !hw_load) |=> ($stable(reg_q) && !wstrobe));
  assert_commit_low_R5: assert property (@(posedge clk) disable iff (rst)
    wstrobe |-> (reg_q[SUB_W-1:0] == $past(wdata[SUB_W-1:0])));
  assert_hw_load_R9: assert property (@(posedge clk) disable iff (rst)
    (hw_load && !commit) |=> (reg_q == $past(hw_data) && !wstrobe));
endmodule

// File: rtl/csr_split_rd.sv
`timescale 1ns/1ps
module csr_split_rd
  import csr_split_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int SUB_W = 8,
  parameter int BUS_W = 32,
  parameter int OFF_W = 4,
  localparam int NSUB = REG_W / SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  csr_acc_t         acc,
  input  logic [OFF_W-1:0] offs,
  input  logic [REG_W-1:0] reg_q,
  output logic [BUS_W-1:0] rdata,
  output logic             rvalid
);
  logic [REG_W-1:0] snap;
  logic [REG_W-1:0] src;
  logic [SUB_W-1:0] chunk;

  always_comb begin
    src   = acc.first ? reg_q : snap;
    chunk = '0;
    if (acc.hit)
      chunk = src[(NSUB - 1 - int'(offs)) * SUB_W +: SUB_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap   <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= acc.rd;
      if (acc.rd) begin
        rdata <= {{(BUS_W-SUB_W){1'b0}}, chunk};
        if (acc.first) snap <= reg_q;
      end
    end
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rdata[BUS_W-1:SUB_W] == '0);
  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (rst)
    (acc.rd && !acc.hit) |=> (rdata == '0));
  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(acc.rd));
endmodule

// File: rtl/csr_split_bridge.sv
`timescale 1ns/1ps
module csr_split_bridge
  import csr_split_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32,
  parameter int REG_W  = 32,
  parameter int SUB_W  = 8,
  localparam int NSUB  = REG_W / SUB_W,
  localparam int OFF_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              hw_load,
  input  logic [REG_W-1:0]  hw_data,
  output logic [REG_W-1:0]  reg_value,
  output logic              reg_wstrobe
);
  csr_acc_t         acc;
  logic [OFF_W-1:0] offs;

  csr_split_decode #(.ADDR_W(ADDR_W), .NSUB(NSUB)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .acc(acc), .offs(offs)
  );

  csr_split_wr #(.REG_W(REG_W), .SUB_W(SUB_W), .BUS_W(BUS_W), .OFF_W(OFF_W)) u_wr (
    .clk(clk), .rst(rst), .acc(acc), .offs(offs), .wdata(bus_wdata),
    .hw_load(hw_load), .hw_data(hw_data), .reg_q(reg_value), .wstrobe(reg_wstrobe)
  );

  csr_split_rd #(.REG_W(REG_W), .SUB_W(SUB_W), .BUS_W(BUS_W), .OFF_W(OFF_W)) u_rd (
    .clk(clk), .rst(rst), .acc(acc), .offs(offs), .reg_q(reg_value),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  initial begin
    assert_geometry_R3: assert (REG_W % SUB_W == 0 && NSUB >= 2 && SUB_W < BUS_W
                                && NSUB <= (1 << OFF_W));
  end

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (reg_value == '0 && !reg_wstrobe && !bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/csr_split_bridge_tb.sv
`timescale 1ns/1ps
module csr_split_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel [2];
  logic        we  [2];
  logic [5:0]  addr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        rvalid [2];
  logic        hwl [2];
  logic [31:0] hwd [2];
  logic [31:0] regv [2];
  logic        stb [2];
  int n_chk = 0, n_fail = 0;
  int swid [2];

  always #2.5 clk = ~clk;

  csr_split_bridge #(.SUB_W(8)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(sel[0]), .bus_we(we[0]), .bus_addr(addr[0]),
    .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .bus_rvalid(rvalid[0]),
    .hw_load(hwl[0]), .hw_data(hwd[0]), .reg_value(regv[0]), .reg_wstrobe(stb[0]));

  csr_split_bridge #(.SUB_W(16)) u_dut16 (
    .clk(clk), .rst(rst), .bus_sel(sel[1]), .bus_we(we[1]), .bus_addr(addr[1]),
    .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .bus_rvalid(rvalid[1]),
    .hw_load(hwl[1]), .hw_data(hwd[1]), .reg_value(regv[1]), .reg_wstrobe(stb[1]));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] piece(logic [31:0] v, int k, int sw);
    return (v >> (32 - (k + 1) * sw)) & ((32'h1 << sw) - 1);
  endfunction

  task automatic bus_wr(int d, int off, logic [31:0] data);
    @(negedge clk);
    sel[d] = 1; we[d] = 1; addr[d] = 6'(off * 4); wdata[d] = data;
    @(negedge clk);
    sel[d] = 0; we[d] = 0;
  endtask

  task automatic bus_rd(int d, int off, int lowb, output logic [31:0] data, output logic v);
    @(negedge clk);
    sel[d] = 1; we[d] = 0; addr[d] = 6'(off * 4 + lowb);
    @(negedge clk);
    sel[d] = 0;
    data = rdata[d]; v = rvalid[d];
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] prev, v, w, r;
    logic vl;
    int nsub;
    swid[0] = 8; swid[1] = 16;
    for (int d = 0; d < 2; d++) begin
      sel[d] = 0; we[d] = 0; addr[d] = 0; wdata[d] = 0; hwl[d] = 0; hwd[d] = 0;
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R1 reg", regv[d], 0);
      chk("R1 strobe/rvalid", {30'b0, stb[d], rvalid[d]}, 0);
      chk("R1 rdata", rdata[d], 0);
    end
    rst = 0;

    for (int d = 0; d < 2; d++) begin
      nsub = 32 / swid[d];
      prev = 0;
      for (int p = 0; p < 8; p++) begin
        v = (32'(p) * 32'h2468ACE1) ^ 32'h12345678;
        for (int k = 0; k < nsub; k++) begin
          // R6: junk above the chunk width
          bus_wr(d, k, piece(v, k, swid[d]) | (32'hDEADBE00 << (swid[d] - 8)));
          if (k < nsub - 1) begin
            chk("R4 reg unchanged", regv[d], prev);
            chk("R4 no strobe", {31'b0, stb[d]}, 0);
          end else begin
            chk("R5 R6 commit value", regv[d], v);
            chk("R5 strobe high", {31'b0, stb[d]}, 1);
            @(negedge clk);
            chk("R5 strobe one cycle", {31'b0, stb[d]}, 0);
          end
        end
        prev = v;
        for (int k = 0; k < nsub; k++) begin
          bus_rd(d, k, (k + p) % 4, r, vl);
          chk(d == 0 ? "R2 R10 slice" : "R3 slice16", r, piece(v, k, swid[d]));
          chk("R10 rvalid", {31'b0, vl}, 1);
        end
        @(negedge clk);
        chk("R10 rvalid drops", {31'b0, rvalid[d]}, 0);
        bus_rd(d, nsub + p, 0, r, vl);
        chk("R8 out-of-range read", r, 0);
      end
    end

    // R8: write beyond range affects neither register nor shadow
    bus_wr(0, 0, 32'hA1); bus_wr(0, 1, 32'hB2); bus_wr(0, 2, 32'hC3);
    bus_wr(0, 7, 32'hFF);
    chk("R8 no strobe", {31'b0, stb[0]}, 0);
    chk("R8 reg unchanged", regv[0], prev);
    bus_wr(0, 3, 32'hD4);
    chk("R8 shadow intact", regv[0], 32'hA1B2C3D4);
    bus_wr(1, 3, 32'h9999);
    chk("R3 offset3 out of range on 16-bit", {31'b0, stb[1]}, 0);

    // R7: snapshot coherence across a hardware update
    v = 32'hA1B2C3D4; w = 32'h5E6F7081;
    bus_rd(0, 0, 0, r, vl);
    chk("R7 first slice", r, 32'hA1);
    @(negedge clk); hwl[0] = 1; hwd[0] = w;
    @(negedge clk); hwl[0] = 0;
    chk("R9 hw load", regv[0], w);
    chk("R9 no strobe", {31'b0, stb[0]}, 0);
    for (int k = 1; k < 4; k++) begin
      bus_rd(0, k, 0, r, vl);
      chk("R7 snapshot slice", r, piece(v, k, 8));
    end
    bus_rd(0, 0, 0, r, vl);
    chk("R7 fresh capture", r, 32'h5E);

    // R9: bus commit wins over same-cycle hardware load
    bus_wr(1, 0, 32'h4321);
    @(negedge clk);
    sel[1] = 1; we[1] = 1; addr[1] = 6'd4; wdata[1] = 32'h8765;
    hwl[1] = 1; hwd[1] = 32'h0BADF00D;
    @(negedge clk);
    sel[1] = 0; we[1] = 0; hwl[1] = 0;
    chk("R9 bus priority", regv[1], 32'h43218765);
    chk("R9 R5 strobe on priority", {31'b0, stb[1]}, 1);

    finish_up();
  end
endmodule